// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space requester and a flat, memory-like configuration window. Each request names a bus number, an 8-bit device/function number and a 12-bit register offset. The block packs these three fields into one window address. Before any access goes out, it decides whether the access is allowed.

The decision depends on two side inputs: the number of the root bus and a link-up status bit. On the root bus only device/function 0 exists. Any other bus lies behind the link, so it can only be reached while the link is up.

An allowed access is issued to the window for exactly one cycle, and its response comes back a fixed number of cycles later. A refused access never reaches the window. It still completes with a response: a refused read returns all ones, and a refused write is discarded. Only one access is handled at a time, and any request that arrives while an access is in flight is dropped.

Top module: `ecam_xlate`

## Requirements
- R1: The window address is the bus number in bits 27:20, the device/function number in bits 19:12 and the register offset in bits 11:0, with bits 1:0 always forced to zero (dword alignment).
- R2: A request to the root bus (`reqBus == rootBus`) with device/function 0 is accepted whatever the value of `linkUp`.
- R3: A request to the root bus with any nonzero device/function is refused.
- R4: A request to any bus other than the root bus is refused while `linkUp` is 0.
- R5: A request to a bus other than the root bus is accepted while `linkUp` is 1, for any device/function.
- R6: A refused read does not drive `winValid`. In the cycle after the request, it raises `rspDone` with `rspOk` = 0 and `rspRdata` = 0xFFFFFFFF.
- R7: A refused write never reaches the window, so no window write happens. In the cycle after the request, it raises `rspDone` with `rspOk` = 0 and `rspRdata` = 0.
- R8: An accepted request drives `winValid` high for exactly one cycle, the cycle after the request. `winWrite` and `winWdata` carry the request's direction and data. `rspDone` with `rspOk` = 1 follows two cycles after `winValid`.
- R9: An accepted read returns in `rspRdata` the window's read data, which is sampled one cycle after `winValid`. An accepted write returns 0.
- R10: A request presented while an accepted access is still in flight (the two cycles after it is taken) is dropped. It produces no window access and no response.
- R11: While `rstN` is low and after reset, `winValid`, `rspDone` and `rspOk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 8 | Target bus number |
| reqDevFn | input | 8 | Target device/function number |
| reqReg | input | 12 | Register byte offset |
| reqWdata | input | 32 | Write data |
| rootBus | input | 8 | Number of the root bus |
| linkUp | input | 1 | 1 while the downstream link is up |
| winValid | output | 1 | Window access strobe, one cycle long |
| winWrite | output | 1 | Window access direction |
| winAddr | output | 28 | Window address |
| winWdata | output | 32 | Window write data |
| winRdata | input | 32 | Window read data, valid the cycle after `winValid` |
| rspDone | output | 1 | Completion pulse |
| rspOk | output | 1 | 1 = access was accepted |
| rspRdata | output | 32 | Read data, or all ones for a refused read |

## Verification
A table of requests covers several cases for each gating rule:
- root bus with device/function 0, with the link both down and up;
- root bus with nonzero device/function;
- buses other than the root bus, with the link down and with the link up;
- a root bus number other than zero.

Together these separate a gate that compares against the root bus from one that compares against bus 0. They also separate a gate that checks the link from one that ignores it. Reads and writes are mixed across the table, so the all-ones read response and the silently dropped write are each tested against the other direction.

Extreme field values check the packing and the alignment, including a register offset with its low bits set and all-ones bus and device/function fields. A directed test then presents a request mid-access to show that it is dropped.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
  localparam int BUS_W   = 8;
  localparam int DEVFN_W = 8;
  localparam int REG_W   = 12;
  localparam int DATA_W  = 32;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LAUNCH  = 2'd1,
    ST_COLLECT = 2'd2
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // request taken this cycle
    logic rejectNow; // request taken and refused
    logic launch;    // window access active
    logic finish;    // window data ready, complete
  } ctrlStrobe_t;
endpackage

// File: rtl/ecam_gate.sv
module ecam_gate #(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8
) (
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devFn,
  input  logic [BUS_W-1:0]   rootBus,
  input  logic               linkUp,
  output logic               accessOk
);
  logic onRoot;
  logic devZero;

  always_comb begin
    onRoot  = (bus == rootBus);
    devZero = (devFn == '0);
    // Root bus: a single device below the port. Other buses: need link.
    if (onRoot) accessOk = devZero;
    else        accessOk = linkUp;
  end
endmodule

// File: rtl/ecam_ctrl.sv
module ecam_ctrl
  import ecam_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        accessOk,
  output ctrlStrobe_t strb
);
  ctrlState_t state, stateNext;

  always_comb begin
    strb.capture   = (state == ST_IDLE) && reqValid;
    strb.rejectNow = strb.capture && !accessOk;
    strb.launch    = (state == ST_LAUNCH);
    strb.finish    = (state == ST_COLLECT);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (reqValid && accessOk) stateNext = ST_LAUNCH;
      ST_LAUNCH:  stateNext = ST_COLLECT;
      ST_COLLECT: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/ecam_datapath.sv
module ecam_datapath
  import ecam_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int REG_W   = 12,
  parameter int DATA_W  = 32,
  localparam int ADDR_W = BUS_W + DEVFN_W + REG_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic               reqWrite,
  input  logic [BUS_W-1:0]   reqBus,
  input  logic [DEVFN_W-1:0] reqDevFn,
  input  logic [REG_W-1:0]   reqReg,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [BUS_W-1:0]   rootBus,
  input  logic               linkUp,
  output logic               accessOk,
  output logic [ADDR_W-1:0]  winAddr,
  output logic               winWrite,
  output logic [DATA_W-1:0]  winWdata,
  input  logic [DATA_W-1:0]  winRdata,
  output logic               rspDone,
  output logic               rspOk,
  output logic [DATA_W-1:0]  rspRdata
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  logic [BUS_W-1:0]   busQ;
  logic [DEVFN_W-1:0] devFnQ;
  logic [REG_W-1:0]   regQ;
  logic [DATA_W-1:0]  wdataQ;
  logic               writeQ;

  ecam_gate #(.BUS_W(BUS_W), .DEVFN_W(DEVFN_W)) u_gate (
    .bus      (reqBus),
    .devFn    (reqDevFn),
    .rootBus  (rootBus),
    .linkUp   (linkUp),
    .accessOk (accessOk)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ   <= '0;
      devFnQ <= '0;
      regQ   <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (strb.capture) begin
      busQ   <= reqBus;
      devFnQ <= reqDevFn;
      regQ   <= reqReg;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
    end
  end

  always_comb begin
    winAddr  = {busQ, devFnQ, regQ} & ALIGN_MASK;
    winWrite = writeQ;
    winWdata = wdataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspDone  <= 1'b0;
      rspOk    <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspDone <= strb.finish | strb.rejectNow;
      rspOk   <= strb.finish;
      if (strb.rejectNow)
        rspRdata <= reqWrite ? '0 : '1;
      else if (strb.finish)
        rspRdata <= writeQ ? '0 : winRdata;
    end
  end
endmodule

// File: rtl/ecam_xlate.sv
module ecam_xlate
  import ecam_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                reqValid,
  input  logic                                reqWrite,
  input  logic [BUS_W-1:0]                    reqBus,
  input  logic [DEVFN_W-1:0]                  reqDevFn,
  input  logic [REG_W-1:0]                    reqReg,
  input  logic [DATA_W-1:0]                   reqWdata,
  input  logic [BUS_W-1:0]                    rootBus,
  input  logic                                linkUp,
  output logic                                winValid,
  output logic                                winWrite,
  output logic [BUS_W+DEVFN_W+REG_W-1:0]      winAddr,
  output logic [DATA_W-1:0]                   winWdata,
  input  logic [DATA_W-1:0]                   winRdata,
  output logic                                rspDone,
  output logic                                rspOk,
  output logic [DATA_W-1:0]                   rspRdata
);
  ctrlStrobe_t strb;
  logic        accessOk;

  ecam_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .accessOk (accessOk),
    .strb     (strb)
  );

  ecam_datapath #(
    .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqWrite (reqWrite),
    .reqBus   (reqBus),
    .reqDevFn (reqDevFn),
    .reqReg   (reqReg),
    .reqWdata (reqWdata),
    .rootBus  (rootBus),
    .linkUp   (linkUp),
    .accessOk (accessOk),
    .winAddr  (winAddr),
    .winWrite (winWrite),
    .winWdata (winWdata),
    .winRdata (winRdata),
    .rspDone  (rspDone),
    .rspOk    (rspOk),
    .rspRdata (rspRdata)
  );

  assign winValid = strb.launch;
endmodule

// File: rtl/ecam_xlate_chk.sv
module ecam_xlate_chk
  import ecam_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input ctrlStrobe_t                    strb,
  input logic                           reqWrite,
  input logic [BUS_W-1:0]               reqBus,
  input logic [DEVFN_W-1:0]             reqDevFn,
  input logic [REG_W-1:0]               reqReg,
  input logic [BUS_W-1:0]               rootBus,
  input logic                           linkUp,
  input logic                           winValid,
  input logic [BUS_W+DEVFN_W+REG_W-1:0] winAddr,
  input logic                           rspDone,
  input logic                           rspOk,
  input logic [DATA_W-1:0]              rspRdata
);
  p_addr_pack_r1: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> winAddr == {$past(reqBus), $past(reqDevFn), $past(reqReg[REG_W-1:2]), 2'b00});

  p_root_dev0_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && reqBus == rootBus && reqDevFn == '0 |=> winValid);

  p_root_other_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && reqBus == rootBus && reqDevFn != '0 |=> rspDone && !rspOk && !winValid);

  p_link_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && reqBus != rootBus && !linkUp |=> rspDone && !rspOk && !winValid);

  p_link_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && reqBus != rootBus && linkUp |=> winValid);

  p_reject_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rejectNow && !reqWrite |=> rspRdata == '1);

  p_win_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    winValid |=> !winValid ##1 (rspDone && rspOk));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({winValid, rspDone}));

  p_idle_out_r11: assert property (@(posedge clk)
    !rstN |=> !winValid && !rspDone && !rspOk);
endmodule

bind ecam_xlate ecam_xlate_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .reqWrite (reqWrite),
  .reqBus   (reqBus),
  .reqDevFn (reqDevFn),
  .reqReg   (reqReg),
  .rootBus  (rootBus),
  .linkUp   (linkUp),
  .winValid (winValid),
  .winAddr  (winAddr),
  .rspDone  (rspDone),
  .rspOk    (rspOk),
  .rspRdata (rspRdata)
);

// File: tb/ecam_xlate_tb.sv
module ecam_xlate_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [7:0]  devFn;
    logic [11:0] regOff;
    logic [7:0]  root;
    logic        link;
    logic [31:0] wdata;
    logic        ok;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 8'h00, 12'h010, 8'h00, 1'b0, 32'h0,         1'b1}, // R2 link down
    '{1'b1, 8'h00, 8'h00, 12'hFFC, 8'h00, 1'b1, 32'hDEADBEEF,  1'b1}, // R2 write
    '{1'b0, 8'h00, 8'h08, 12'h000, 8'h00, 1'b1, 32'h0,         1'b0}, // R3 R6
    '{1'b1, 8'h00, 8'h01, 12'h004, 8'h00, 1'b1, 32'h12345678,  1'b0}, // R3 R7
    '{1'b0, 8'h01, 8'h00, 12'h000, 8'h00, 1'b0, 32'h0,         1'b0}, // R4 R6
    '{1'b1, 8'h05, 8'h2A, 12'h040, 8'h00, 1'b0, 32'hCAFEF00D,  1'b0}, // R4 R7
    '{1'b0, 8'h01, 8'h11, 12'h123, 8'h00, 1'b1, 32'h0,         1'b1}, // R5 R1 low bits
    '{1'b1, 8'hFF, 8'hFF, 12'hFFF, 8'h00, 1'b1, 32'hA5A55A5A,  1'b1}, // R5 R1 extremes
    '{1'b0, 8'h03, 8'h00, 12'h008, 8'h03, 1'b0, 32'h0,         1'b1}, // R2 root=3
    '{1'b0, 8'h03, 8'h04, 12'h008, 8'h03, 1'b1, 32'h0,         1'b0}, // R3 root=3
    '{1'b0, 8'h00, 8'h00, 12'h00C, 8'h03, 1'b0, 32'h0,         1'b0}  // R4 bus0 not root
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [7:0]  reqDevFn = '0;
  logic [11:0] reqReg = '0;
  logic [31:0] reqWdata = '0;
  logic [7:0]  rootBus = '0;
  logic        linkUp = 1'b0;
  logic        winValid;
  logic        winWrite;
  logic [27:0] winAddr;
  logic [31:0] winWdata;
  logic [31:0] winRdata;
  logic        rspDone;
  logic        rspOk;
  logic [31:0] rspRdata;

  int nCompared = 0;
  int nMismatch = 0;
  int wrCount = 0;
  logic [27:0] lastWrAddr;
  logic [31:0] lastWrData;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecam_xlate u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDevFn(reqDevFn), .reqReg(reqReg), .reqWdata(reqWdata),
    .rootBus(rootBus), .linkUp(linkUp), .winValid(winValid), .winWrite(winWrite),
    .winAddr(winAddr), .winWdata(winWdata), .winRdata(winRdata),
    .rspDone(rspDone), .rspOk(rspOk), .rspRdata(rspRdata)
  );

  // Window model: synchronous read returns a tag plus the address
  always_ff @(posedge clk) begin
    if (winValid) begin
      if (winWrite) begin
        wrCount    <= wrCount + 1;
        lastWrAddr <= winAddr;
        lastWrData <= winWdata;
      end else begin
        winRdata <= {4'h5, winAddr};
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    logic [27:0] expAddr;
    int wrBefore;
    expAddr  = {v.bus, v.devFn, v.regOff & 12'hFFC};
    wrBefore = wrCount;
    reqValid = 1'b1; reqWrite = v.wr; reqBus = v.bus; reqDevFn = v.devFn;
    reqReg = v.regOff; reqWdata = v.wdata; rootBus = v.root; linkUp = v.link;
    @(negedge clk);
    reqValid = 1'b0;
    if (v.ok) begin
      check("R8", $sformatf("v%0d winValid", idx), 32'(winValid), 32'd1);
      check("R1", $sformatf("v%0d winAddr", idx), 32'(winAddr), 32'(expAddr));
      check("R8", $sformatf("v%0d winWrite", idx), 32'(winWrite), 32'(v.wr));
      check("R2 R5", $sformatf("v%0d early done", idx), 32'(rspDone), 32'd0);
      @(negedge clk);
      check("R8", $sformatf("v%0d pulse end", idx), 32'(winValid), 32'd0);
      if (v.wr) begin
        check("R8", $sformatf("v%0d wr addr", idx), 32'(lastWrAddr), 32'(expAddr));
        check("R8", $sformatf("v%0d wr data", idx), lastWrData, v.wdata);
      end
      @(negedge clk);
      check("R8", $sformatf("v%0d done", idx), 32'(rspDone), 32'd1);
      check("R8", $sformatf("v%0d ok", idx), 32'(rspOk), 32'd1);
      check("R9", $sformatf("v%0d rdata", idx), rspRdata,
            v.wr ? 32'h0 : {4'h5, expAddr});
    end else begin
      check("R6 R7", $sformatf("v%0d no window", idx), 32'(winValid), 32'd0);
      check("R3 R4", $sformatf("v%0d done", idx), 32'(rspDone), 32'd1);
      check("R3 R4", $sformatf("v%0d ok", idx), 32'(rspOk), 32'd0);
      check(v.wr ? "R7" : "R6", $sformatf("v%0d rdata", idx), rspRdata,
            v.wr ? 32'h0 : 32'hFFFFFFFF);
      @(negedge clk);
      check("R6 R7", $sformatf("v%0d still no window", idx), 32'(winValid), 32'd0);
      check("R7", $sformatf("v%0d write count", idx), 32'(wrCount), 32'(wrBefore));
    end
    @(negedge clk);
    check("R8", $sformatf("v%0d done single", idx), 32'(rspDone), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nMismatch++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    int wrBefore;
    repeat (3) @(negedge clk);
    check("R11", "reset winValid", 32'(winValid), 32'd0);
    check("R11", "reset rspDone", 32'(rspDone), 32'd0);
    check("R11", "reset rspOk", 32'(rspOk), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "post-reset rspDone", 32'(rspDone), 32'd0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);

    // R10: requests presented during an accepted access are dropped
    wrBefore = wrCount;
    reqValid = 1'b1; reqWrite = 1'b0; reqBus = 8'h02; reqDevFn = 8'h00;
    reqReg = 12'h020; rootBus = 8'h00; linkUp = 1'b1;
    @(negedge clk);
    check("R10", "first taken", 32'(winValid), 32'd1);
    reqWrite = 1'b1; reqBus = 8'h04; reqWdata = 32'h0BADF00D; // would be accepted
    @(negedge clk);
    check("R10", "no second window", 32'(winValid), 32'd0);
    check("R10", "no early done", 32'(rspDone), 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    check("R10", "first done", 32'(rspDone), 32'd1);
    check("R10", "first data", rspRdata, {4'h5, 8'h02, 8'h00, 12'h020});
    @(negedge clk);
    check("R10", "no extra done", 32'(rspDone), 32'd0);
    check("R10", "no extra window", 32'(winValid), 32'd0);
    check("R10", "no write", 32'(wrCount), 32'(wrBefore));

    // R11: reset mid-access clears outputs
    reqValid = 1'b1; reqWrite = 1'b0; reqBus = 8'h00; reqDevFn = 8'h00;
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check("R11", "reset kills window", 32'(winValid), 32'd0);
    check("R11", "reset kills done", 32'(rspDone), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "no stale done", 32'(rspDone), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end
endmodule